// File: doc/BRIEF.md
# Expansion RAM Row Selector with DMA Guard

This block picks the DRAM row on a memory expansion card that answers each bus cycle. The host decodes the card's four lower rows itself and passes a 2-bit row code that is correct in processor cycles and in DMA cycles alike. Two further rows sit above them. The card reaches those rows by decoding a bank number that it captures from the data bus on each rising edge of the PH2 phase.

During DMA the processor is off the bus and nothing drives a bank number onto it. The captured value is therefore left over from the last processor cycle and cannot be trusted. The block refuses to steer any DMA access with that value. A DMA cycle that would land in the upper rows drives no strobe and raises a one-cycle blocked flag instead. PH2 is asynchronous to the system clock, so it passes through a two-flop synchronizer and an edge detector. Row strobes and the blocked flag are registered and appear one system clock after the inputs that produce them. All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake applies.

Top module: `xram_row_select`

## Requirements
- R1: While reset is active (rst_n low), all row strobes and the blocked flag are low, and the captured bank is marked invalid.
- R2: When card_sel is low, every strobe and the blocked flag are low on the next clock.
- R3: When the cycle does not hit an upper row, strobe number row_code (0 to 3) is the only strobe high one clock later. This holds whether dma_active is high or low.
- R4: On a synchronized rising edge of ph2 with dma_active low, data_bus is captured as the bank and marked valid.
- R5: Upper-row decode uses UP_BASE = 0x60. With big_rows = 0 (256K rows, 4 banks each), banks 0x60–0x63 select strobe 4 and banks 0x64–0x67 select strobe 5. With big_rows = 1 (1 MB rows, 16 banks each), banks 0x60–0x6F select strobe 4 and banks 0x70–0x7F select strobe 5. Any other bank falls through to row_code.
- R6: A cycle with card_sel and dma_active high, and a valid captured bank in the upper range, drives no strobe. The blocked flag is high for that one cycle.
- R7: Until a processor cycle has loaded the bank, no upper row can be selected, and row_code steers every access.
- R8: At most one strobe is high at any time. The blocked flag is never high together with a strobe.
- R9: A ph2 rising edge that arrives while dma_active is high leaves the captured bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph2 | input | 1 | Bus phase clock, asynchronous to clk |
| data_bus | input | 8 | Host data bus carrying the bank number in processor cycles |
| row_code | input | 2 | Host-decoded lower-row number |
| dma_active | input | 1 | High during DMA cycles |
| card_sel | input | 1 | High when the cycle targets this card |
| big_rows | input | 1 | 0 = 256K rows, 1 = 1 MB rows |
| row_stb | output | 6 | One-hot row strobes, registered |
| blocked | output | 1 | One-cycle pulse for a refused DMA upper-row access |

## Verification
The hardest case to reach is a DMA cycle where the captured bank is both valid and stale. To create it, the bench first runs a processor PH2 cycle that puts an upper-range bank on the bus, then raises dma_active. It then pulses PH2 again under DMA with a different bank on the bus. The bench confirms that the refusal still happens, and that once DMA ends the older bank, not the DMA-time value, selects the upper row. Each row size is exercised at the bank values just inside and just outside the upper window.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
  localparam int LOW_ROWS = 4;

  function automatic logic [LOW_ROWS-1:0] code_to_onehot(input logic [1:0] code);
    logic [LOW_ROWS-1:0] v;
    v = '0;
    v[code] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/ph2_rise_detect.sv
module ph2_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ph2,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ph2;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;

  // R4
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/bank_capture.sv
module bank_capture #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              dma_active,
  input  logic [BANK_W-1:0] data_bus,
  output logic [BANK_W-1:0] bank_q,
  output logic              bank_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q  <= '0;
      bank_ok <= 1'b0;
    end else if (rise && !dma_active) begin
      bank_q  <= data_bus;
      bank_ok <= 1'b1;
    end
  end

  // R9
  dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_active |=> $stable(bank_q));
  // R7
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_ok |=> bank_ok);
endmodule

// File: rtl/row_decode.sv
module row_decode
  import xrs_pkg::*;
#(
  parameter int          BANK_W     = 8,
  parameter int          NROWS      = 6,
  parameter logic [7:0]  UP_BASE    = 8'h60,
  parameter int          SMALL_SH   = 2,
  parameter int          BIG_SH     = 4
) (
  input  logic              big_rows,
  input  logic              dma_active,
  input  logic [1:0]        row_code,
  input  logic [BANK_W-1:0] bank_q,
  input  logic              bank_ok,
  output logic [NROWS-1:0]  stb_n,
  output logic              refuse
);
  localparam int NUP = NROWS - LOW_ROWS;

  logic [BANK_W-1:0] off, idx;
  logic [BANK_W:0]   span_all;
  logic              in_up;
  logic [NUP-1:0]    up_hit;

  always_comb begin
    off      = bank_q - BANK_W'(UP_BASE);
    span_all = big_rows ? (BANK_W+1)'(NUP << BIG_SH) : (BANK_W+1)'(NUP << SMALL_SH);
    idx      = big_rows ? (off >> BIG_SH) : (off >> SMALL_SH);
    in_up    = bank_ok && (bank_q >= BANK_W'(UP_BASE)) && ({1'b0, off} < span_all);
  end

  for (genvar k = 0; k < NUP; k++) begin : g_up
    assign up_hit[k] = in_up && (idx == BANK_W'(k));
  end

  always_comb begin
    refuse = in_up && dma_active;
    if (refuse)     stb_n = '0;
    else if (in_up) stb_n = {up_hit, {LOW_ROWS{1'b0}}};
    else            stb_n = {{NUP{1'b0}}, code_to_onehot(row_code)};
  end
endmodule

// File: rtl/xram_row_select.sv
module xram_row_select #(
  parameter int         BANK_W  = 8,
  parameter int         NROWS   = 6,
  parameter logic [7:0] UP_BASE = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph2,
  input  logic [BANK_W-1:0] data_bus,
  input  logic [1:0]        row_code,
  input  logic              dma_active,
  input  logic              card_sel,
  input  logic              big_rows,
  output logic [NROWS-1:0]  row_stb,
  output logic              blocked
);
  logic              rise;
  logic [BANK_W-1:0] bank_q;
  logic              bank_ok;
  logic [NROWS-1:0]  stb_n;
  logic              refuse;

  ph2_rise_detect u_sync (
    .clk(clk), .rst_n(rst_n), .ph2(ph2), .rise(rise)
  );

  bank_capture #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .rise(rise), .dma_active(dma_active),
    .data_bus(data_bus), .bank_q(bank_q), .bank_ok(bank_ok)
  );

  row_decode #(.BANK_W(BANK_W), .NROWS(NROWS), .UP_BASE(UP_BASE)) u_dec (
    .big_rows(big_rows), .dma_active(dma_active), .row_code(row_code),
    .bank_q(bank_q), .bank_ok(bank_ok), .stb_n(stb_n), .refuse(refuse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_stb <= '0;
      blocked <= 1'b0;
    end else begin
      row_stb <= card_sel ? stb_n : '0;
      blocked <= card_sel & refuse;
    end
  end

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_stb));
  // R8
  blk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> (row_stb == '0));
  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !card_sel |=> (row_stb == '0) && !blocked);
  // R6
  dma_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_sel && dma_active |=> (row_stb[NROWS-1:4] == '0));
endmodule

// File: tb/xram_row_select_tb.sv
module xram_row_select_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ph2 = 1'b0;
  logic [7:0] data_bus = 8'h00;
  logic [1:0] row_code = 2'd0;
  logic       dma_active = 1'b0;
  logic       card_sel = 1'b0;
  logic       big_rows = 1'b0;
  logic [5:0] row_stb;
  logic       blocked;

  int checks = 0;
  int fails  = 0;
  logic       m_ok = 1'b0;
  logic [7:0] m_bank = 8'h00;

  typedef struct {
    logic [5:0] stb;
    logic       blk;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  xram_row_select u_dut (
    .clk(clk), .rst_n(rst_n), .ph2(ph2), .data_bus(data_bus),
    .row_code(row_code), .dma_active(dma_active), .card_sel(card_sel),
    .big_rows(big_rows), .row_stb(row_stb), .blocked(blocked)
  );

  function automatic exp_t model(input logic sel, input logic [1:0] code,
                                 input logic dma, input logic big, input string tag);
    exp_t e;
    int off, span;
    logic up;
    e.tag = tag; e.stb = '0; e.blk = 1'b0;
    off  = int'(m_bank) - 'h60;
    span = big ? 16 : 4;
    up   = m_ok && off >= 0 && off < 2 * span;
    if (sel) begin
      if (up && dma)  e.blk = 1'b1;
      else if (up)    e.stb[4 + off / span] = 1'b1;
      else            e.stb[code] = 1'b1;
    end
    return e;
  endfunction

  task automatic drive(input logic sel, input logic [1:0] code, input logic dma,
                       input logic big, input string tag);
    @(negedge clk);
    card_sel = sel; row_code = code; dma_active = dma; big_rows = big;
    q.push_back(model(sel, code, dma, big, tag));
  endtask

  task automatic load(input logic [7:0] b, input logic dma);
    @(negedge clk);
    card_sel = 1'b0; dma_active = dma; data_bus = b; ph2 = 1'b1;
    q.push_back(model(1'b0, 2'd0, dma, big_rows, "load"));
    repeat (5) begin
      @(negedge clk);
      q.push_back(model(1'b0, 2'd0, dma, big_rows, "load"));
    end
    ph2 = 1'b0;
    repeat (2) begin
      @(negedge clk);
      q.push_back(model(1'b0, 2'd0, dma, big_rows, "load"));
    end
    if (!dma) begin m_bank = b; m_ok = 1'b1; end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (row_stb !== e.stb || blocked !== e.blk) begin
        fails++;
        $display("FAIL %s: stb=%b blk=%b expected stb=%b blk=%b",
                 e.tag, row_stb, blocked, e.stb, e.blk);
      end
      // R8: exclusivity on every observed cycle
      checks++;
      if ($countones(row_stb) > 1 || (blocked && row_stb != 0)) begin
        fails++;
        $display("FAIL R8: stb=%b blk=%b expected onehot0 and exclusive", row_stb, blocked);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    card_sel = 1'b1; ph2 = 1'b1; data_bus = 8'h61;
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    checks++;
    if (row_stb !== 6'b0 || blocked !== 1'b0) begin
      fails++;
      $display("FAIL R1: stb=%b blk=%b expected 000000 0", row_stb, blocked);
    end
    ph2 = 1'b0; card_sel = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    // R7: bank 0x61 on bus but never captured, so row_code rules
    drive(1, 2'd2, 0, 0, "R7 no capture yet");
    drive(1, 2'd1, 1, 0, "R7 dma before capture");
    // R3: lower rows in processor and DMA cycles
    for (int c = 0; c < 4; c++) drive(1, 2'(c), 0, 0, "R3 cpu");
    for (int c = 0; c < 4; c++) drive(1, 2'(c), 1, 1, "R3 dma");
    // R2: deselected
    drive(0, 2'd3, 0, 0, "R2 idle");
    drive(0, 2'd0, 1, 1, "R2 idle dma");
    // R4/R5 small rows
    load(8'h60, 0); drive(1, 2'd0, 0, 0, "R5 small lo edge row4");
    load(8'h63, 0); drive(1, 2'd0, 0, 0, "R5 small row4 top");
    load(8'h64, 0); drive(1, 2'd1, 0, 0, "R5 small row5");
    load(8'h67, 0); drive(1, 2'd1, 0, 0, "R5 small row5 top");
    load(8'h68, 0); drive(1, 2'd3, 0, 0, "R5 small out of window");
    load(8'h5F, 0); drive(1, 2'd2, 0, 0, "R5 below window");
    // R5 big rows
    load(8'h6F, 0); drive(1, 2'd0, 0, 1, "R5 big row4 top");
    drive(1, 2'd0, 0, 0, "R5 same bank small out");
    load(8'h70, 0); drive(1, 2'd0, 0, 1, "R5 big row5");
    load(8'h7F, 0); drive(1, 2'd0, 0, 1, "R5 big row5 top");
    load(8'h80, 0); drive(1, 2'd2, 0, 1, "R5 big out");
    // R6: stale upper bank under DMA is refused
    load(8'h65, 0);
    drive(1, 2'd1, 1, 0, "R6 dma refuse");
    drive(1, 2'd2, 1, 0, "R6 dma refuse again");
    drive(0, 2'd2, 1, 0, "R2 dma deselected");
    // R9: capture attempt during DMA is ignored
    load(8'h40, 1);
    drive(1, 2'd3, 1, 0, "R9 still refused");
    drive(1, 2'd3, 0, 0, "R9 old bank row5");
    // R3: DMA with in-window bank absent picks row_code
    load(8'h20, 0);
    drive(1, 2'd2, 1, 0, "R3 dma lower");
    drive(0, 2'd0, 0, 0, "R2 end");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule